// File: doc/BRIEF.md
# Retriggerable RC One-Shot Controller

This block is the digital core of a retriggerable monostable pulse generator whose pulse width is set by an external resistor and capacitor. It runs a three-state machine: **READY**, **DISCH** (discharge) and **MON** (monitor). Its inputs are a single-cycle trigger, a clear, and two comparator flags. One flag reports that the timing node has fallen to the low threshold. The other reports that the node has risen to the high threshold. Its outputs are the pulse, the pulse's complement, and a two-bit command for the tri-state driver on the timing node.

At rest the controller holds the node high and keeps the pulse inactive. A trigger starts a pulse. The node is pulled low until the low-threshold flag is seen. The node driver is then released so the external network can recharge it. When the high-threshold flag is seen, the pulse ends. A trigger that arrives during recharge starts the discharge again, which lengthens the pulse. Clear returns the machine to rest from any state.

The comparator flags come from analog circuits, so each one passes through its own flip-flop synchronizer before the machine uses it. The trigger is expected to already be a clean, synchronous single-cycle pulse.

Top module: `rc_oneshot_ctrl`

Named transitions:
- READY→DISCH on trigger.
- DISCH→MON on the low flag.
- MON→READY on the high flag.
- MON→DISCH on trigger (retrigger).
- any→READY on clear.

In every other case the machine holds its state.

## Requirements
- R1: After reset the machine is in READY: `pulse_o`=0, `pulse_n_o`=1 and `node_drv_o`=2'b11.
- R2: In READY, `node_drv_o`=2'b11 (bit 1 = driver enable, bit 0 = driven value) and `pulse_o`=0. Both comparator flags are ignored in READY.
- R3: In READY, a trigger with clear low moves the machine to DISCH at the next rising edge. From that edge on, `pulse_o`=1 and `node_drv_o`=2'b10, which drives the node low.
- R4: DISCH holds until the synchronized low flag is seen. Triggers and the high flag have no effect in DISCH.
- R5: In DISCH, the synchronized low flag moves the machine to MON. In MON, `node_drv_o`=2'b00 (released) and `pulse_o`=1. MON holds while neither a trigger nor the high flag is present.
- R6: In MON, the synchronized high flag with no trigger returns the machine to READY.
- R7: In MON, a trigger moves the machine back to DISCH. A trigger takes priority over the high flag in the same cycle.
- R8: Clear forces READY at the next edge from any state. Clear takes priority over the trigger and over both flags.
- R9: Each comparator flag passes through two synchronizer flops. A flag change applied before rising edge k affects the state at edge k+2.
- R10: `pulse_n_o` is always the inverse of `pulse_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Single-cycle trigger pulse |
| clr_i | input | 1 | Clear; forces READY |
| at_low_i | input | 1 | Asynchronous flag: node at or below the low threshold |
| at_high_i | input | 1 | Asynchronous flag: node at or above the high threshold |
| pulse_o | output | 1 | Pulse output, active high |
| pulse_n_o | output | 1 | Complement of the pulse output |
| node_drv_o | output | 2 | Node driver command {enable, value}; enable 0 means high impedance |

## Verification
Trigger and clear act at the first rising edge after they are applied, and the outputs follow the state register in that same cycle. A comparator flag needs three edges to take effect: two edges to cross the synchronizer and a third to change the state. The bench drives every input on the falling edge and checks the outputs on the following falling edge. Its reference model applies trigger and clear at once, but applies each flag two steps late, which matches that latency. Directed checks confirm that a flag leaves the outputs unchanged for two edges and changes them at the third.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_DISCH = 2'd1,
        ST_MON   = 2'd2
    } rpc_state_e;

    // node driver command {enable, value}
    localparam logic [1:0] DRV_HIGH = 2'b11;
    localparam logic [1:0] DRV_LOW  = 2'b10;
    localparam logic [1:0] DRV_REL  = 2'b00;

endpackage

// File: rtl/rpc_sync.sv
module rpc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

    // Count edges since reset so that $past never reaches before reset.
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_chk2
            assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd3) |-> (q_o == $past(d_i, 2)));
        end
    endgenerate

endmodule

// File: rtl/rpc_fsm.sv
module rpc_fsm
    import rpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic       clr_i,
    input  logic       low_s_i,
    input  logic       high_s_i,
    output logic       pulse_o,
    output logic       pulse_n_o,
    output logic [1:0] node_drv_o
);

    rpc_state_e state_q, state_d;

    // next-state logic: clear outranks everything
    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = ST_READY;
        end else begin
            unique case (state_q)
                ST_READY: if (trig_i)   state_d = ST_DISCH;
                ST_DISCH: if (low_s_i)  state_d = ST_MON;
                ST_MON: begin
                    if (trig_i)        state_d = ST_DISCH;
                    else if (high_s_i) state_d = ST_READY;
                end
                default:               state_d = ST_READY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_READY: begin pulse_o = 1'b0; node_drv_o = DRV_HIGH; end
            ST_DISCH: begin pulse_o = 1'b1; node_drv_o = DRV_LOW;  end
            ST_MON:   begin pulse_o = 1'b1; node_drv_o = DRV_REL;  end
            default:  begin pulse_o = 1'b0; node_drv_o = DRV_HIGH; end
        endcase
        pulse_n_o = ~pulse_o;
    end

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (state_q == ST_READY));
    assert_ready_trig_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && trig_i && !clr_i) |=> (state_q == ST_DISCH));
    assert_ready_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && !trig_i && !clr_i) |=> (state_q == ST_READY));
    assert_disch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCH && !low_s_i && !clr_i) |=> (state_q == ST_DISCH));
    assert_disch_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCH && low_s_i && !clr_i) |=> (state_q == ST_MON));
    assert_mon_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MON && high_s_i && !trig_i && !clr_i) |=> (state_q == ST_READY));
    assert_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MON && trig_i && !clr_i) |=> (state_q == ST_DISCH));
    assert_pulse_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> (node_drv_o == DRV_LOW));

endmodule

// File: rtl/rc_oneshot_ctrl.sv
module rc_oneshot_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic       clr_i,
    input  logic       at_low_i,
    input  logic       at_high_i,
    output logic       pulse_o,
    output logic       pulse_n_o,
    output logic [1:0] node_drv_o
);

    localparam int FLAG_W = 2;

    logic [FLAG_W-1:0] flags_raw, flags_s;

    assign flags_raw = {at_high_i, at_low_i};

    rpc_sync #(
        .WIDTH  (FLAG_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (flags_raw),
        .q_o   (flags_s)
    );

    rpc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig_i),
        .clr_i      (clr_i),
        .low_s_i    (flags_s[0]),
        .high_s_i   (flags_s[1]),
        .pulse_o    (pulse_o),
        .pulse_n_o  (pulse_n_o),
        .node_drv_o (node_drv_o)
    );

    assert_complement_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o != pulse_n_o);

endmodule

// File: tb/rc_oneshot_ctrl_bench.sv
`timescale 1ns/1ps
module rc_oneshot_ctrl_bench;

    localparam int M_READY = 0, M_DISCH = 1, M_MON = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0, clr = 1'b0, lo = 1'b0, hi = 1'b0;
    logic pulse, pulse_n;
    logic [1:0] drv;

    int n_chk = 0, n_bad = 0;
    int m_state = M_READY;
    logic lo_h1 = 0, lo_h2 = 0, hi_h1 = 0, hi_h2 = 0;

    always #10 clk = ~clk;

    rc_oneshot_ctrl u_rc_oneshot_ctrl (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .clr_i(clr),
        .at_low_i(lo), .at_high_i(hi),
        .pulse_o(pulse), .pulse_n_o(pulse_n), .node_drv_o(drv)
    );

    function automatic logic exp_pulse(int s);
        return (s != M_READY);
    endfunction

    function automatic logic [1:0] exp_drv(int s);
        case (s)
            M_DISCH: return 2'b10;
            M_MON:   return 2'b00;
            default: return 2'b11;
        endcase
    endfunction

    function automatic int next_state(int s, logic t, logic c, logic l, logic h);
        if (c) return M_READY;
        case (s)
            M_READY: return t ? M_DISCH : M_READY;
            M_DISCH: return l ? M_MON : M_DISCH;
            default: return t ? M_DISCH : (h ? M_READY : M_MON);
        endcase
    endfunction

    function automatic string auto_tag(int s, logic t, logic c, logic l, logic h);
        if (c) return "R8";
        case (s)
            M_READY: return t ? "R3" : "R2";
            M_DISCH: return l ? "R5" : "R4";
            default: return t ? "R7" : (h ? "R6" : "R5");
        endcase
    endfunction

    task automatic check_outputs(string tag);
        n_chk++;
        if (pulse !== exp_pulse(m_state) || drv !== exp_drv(m_state)) begin
            n_bad++;
            $display("FAIL %s: pulse=%b drv=%b expected pulse=%b drv=%b",
                     tag, pulse, drv, exp_pulse(m_state), exp_drv(m_state));
        end
        n_chk++;
        if (pulse_n !== ~pulse) begin
            n_bad++;
            $display("FAIL R10: pulse_n=%b expected %b", pulse_n, ~pulse);
        end
    endtask

    // called at a falling edge: drive, take a rising edge, update model, check
    task automatic step(logic t, logic c, logic l, logic h, string tag_ovr = "");
        string tag;
        trig = t; clr = c; lo = l; hi = h;
        tag = (tag_ovr != "") ? tag_ovr : auto_tag(m_state, t, c, lo_h2, hi_h2);
        @(posedge clk);
        m_state = next_state(m_state, t, c, lo_h2, hi_h2);
        lo_h2 = lo_h1; lo_h1 = l;
        hi_h2 = hi_h1; hi_h1 = h;
        @(negedge clk);
        check_outputs(tag);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check_outputs("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1");

        // R2: flags ignored in ready
        step(0, 0, 1, 1, "R2");
        step(0, 0, 1, 1, "R2");
        step(0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, "R2");
        // R3: trigger starts discharge
        step(1, 0, 0, 0, "R3");
        // R4: trigger and high flag ignored in discharge
        step(1, 0, 0, 1, "R4");
        step(0, 0, 0, 1, "R4");
        step(0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, "R4");
        // R9: low flag needs three edges
        step(0, 0, 1, 0, "R9");
        step(0, 0, 1, 0, "R9");
        step(0, 0, 0, 0, "R9");   // third edge: monitor
        step(0, 0, 0, 0, "R5");
        // R7: retrigger outranks high flag
        step(0, 0, 0, 1, "R5");
        step(0, 0, 0, 0, "R5");
        step(1, 0, 0, 0, "R7");   // high seen synced now, trigger wins
        step(0, 0, 1, 0, "R4");
        step(0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, "R5");
        // R6: high flag ends pulse
        step(0, 0, 0, 1, "R6");
        step(0, 0, 0, 0, "R6");
        step(0, 0, 0, 0, "R6");
        // R8: clear from discharge, beats trigger
        step(1, 0, 0, 0, "R3");
        step(1, 1, 1, 1, "R8");
        step(0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, "R8");
        // R8: clear from monitor
        step(1, 0, 0, 0, "R3");
        step(0, 0, 1, 0, "R5");
        step(0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, "R5");
        step(1, 1, 0, 0, "R8");

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic t, c, l, h;
            t = ($urandom % 8) == 0;
            c = ($urandom % 40) == 0;
            l = ($urandom % 4) == 0 ? ~lo : lo;
            h = ($urandom % 4) == 0 ? ~hi : hi;
            step(t, c, l, h);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule